// File: doc/BRIEF.md
# NAND Flash Controller Host Command and Status Interface

This block is the host-facing register front end of a NAND flash controller. A CPU reaches it over a simple single-cycle register bus (write strobe, address, write data, combinational read data). It keeps a control register with a run bit and a twelve-bit interrupt mask. It keeps a thirteen-bit event status register that software clears by writing ones. It also keeps a command buffer of three words, which the host loads by writing the same address repeatedly once the block has asked for a command.

The flash-side engine is not part of this block. Its events arrive as single-cycle pulses on plain inputs: command done, page done, bad block, ready, read-data request, write-data request, single-bit ECC error and double-bit ECC error. A chip-select bit in the first command word steers the per-chip events into the status bits for chip 0 or for chip 1. One interrupt line is raised from the status bits that are set and not masked. The loaded command words, the selected chip and a loaded flag are presented to the engine.

Top module: `nfc_host_if`

## Requirements
- R1: After reset, run, irq, cmd_loaded and cmd_ovf are 0, and the control, status and command-word registers read 0.
- R2: The control register (address 0x00) holds run in bit 28 and the interrupt masks in bits 11:0, and both read back. A write that sets run while run is 0 also sets status bit 0 (command request).
- R3: While run is 0, writes to the command address (0x08) are ignored, and the command words keep their values.
- R4: While run is 1, successive writes to address 0x08 load command words 0, 1 and 2 in that order. The words read back at 0x08, 0x0C and 0x10, and cmd_loaded is 1 once all three are held.
- R5: A write to 0x08 after all three words are held is dropped and sets cmd_ovf. cmd_ovf stays set until reset.
- R6: The status register (address 0x04) records a read-data request in bit 1, a write-data request in bit 2, a single-bit ECC error in bit 3 and a double-bit ECC error in bit 4.
- R7: Bit 24 of command word 0 selects the chip. With chip 0, command done, page done, bad block and ready set status bits 8, 10, 6 and 11. With chip 1 they set bits 7, 9, 5 and 12.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: irq is 1 exactly when some status bit is set and enabled, one cycle after the status change. Mask bit k set to 1 disables status bit k (k < 12). Status bit 12 has no mask.
- R10: run clears by itself on a command-done event, and cmd_loaded drops with it. A host write of 0 to run also clears it. Every new setting of run restarts the load at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| evt_cmd_done | input | 1 | Engine: command finished for the selected chip |
| evt_page_done | input | 1 | Engine: page finished for the selected chip |
| evt_bad_blk | input | 1 | Engine: bad block found on the selected chip |
| evt_ready | input | 1 | Engine: selected chip ready |
| evt_rd_req | input | 1 | Engine: read data waiting |
| evt_wr_req | input | 1 | Engine: write data wanted |
| evt_sb_err | input | 1 | Engine: single-bit ECC error |
| evt_db_err | input | 1 | Engine: double-bit ECC error |
| run | output | 1 | Run bit |
| irq | output | 1 | Interrupt request |
| cmd_loaded | output | 1 | All command words held while running |
| cmd_ovf | output | 1 | Sticky command-write overflow |
| cmd_cs | output | 1 | Chip select taken from command word 0 |
| cmd_words | output | N_WORDS*DATA_W | Command words, word 0 in the low bits |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit address and three command words. With these values the fourth write to the command address is the overflow case. A second arm-and-load pass proves that the load index restarts. Both chip-select values are driven through the same event pulses, so each of the eight routed status positions is observed. The unmaskable top status bit is exercised with every other mask bit set.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  // register byte addresses
  localparam int A_CTRL = 'h00;
  localparam int A_STAT = 'h04;
  localparam int A_CMD  = 'h08;   // write port; word i reads at A_CMD + 4*i

  // control field positions
  localparam int RUN_POS = 28;
  localparam int MASK_W  = 12;

  // status layout
  localparam int STAT_W   = 13;
  localparam int S_CMDREQ = 0;
  localparam int S_RDREQ  = 1;
  localparam int S_WRREQ  = 2;
  localparam int S_SBERR  = 3;
  localparam int S_DBERR  = 4;
  localparam int S_BBD1   = 5;
  localparam int S_BBD0   = 6;
  localparam int S_CDN1   = 7;
  localparam int S_CDN0   = 8;
  localparam int S_PGD1   = 9;
  localparam int S_PGD0   = 10;
  localparam int S_RDY0   = 11;
  localparam int S_RDY1   = 12;

  // chip select position in command word 0
  localparam int CS_POS = 24;

  typedef struct packed {
    logic cmd_done;
    logic page_done;
    logic bad_blk;
    logic ready;
    logic rd_req;
    logic wr_req;
    logic sb_err;
    logic db_err;
  } nfc_evt_t;
endpackage

// File: rtl/nfc_ctrl_reg.sv
module nfc_ctrl_reg
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_run,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              auto_clr,
  output logic              run,
  output logic [MASK_W-1:0] mask,
  output logic              run_rise,
  output logic              run_drop
);
  assign run_rise = wr_ctrl &&  wr_run && !run;
  assign run_drop = wr_ctrl && !wr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mask <= '0;
    end else if (wr_ctrl) begin
      run  <= wr_run;
      mask <= wr_mask;
    end else if (auto_clr) begin
      run  <= 1'b0;
    end
  end
endmodule

// File: rtl/nfc_cmd_buf.sv
module nfc_cmd_buf #(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           restart,
  input  logic                           wr_cmd,
  input  logic                           run,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_WORDS-1:0][DATA_W-1:0] words,
  output logic                           loaded,
  output logic                           ovf
);
  localparam int IDX_W = $clog2(N_WORDS + 1);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(N_WORDS);

  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             drop;

  assign accept = wr_cmd && run && (idx != FULL);
  assign drop   = wr_cmd && run && (idx == FULL);
  assign loaded = run && (idx == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (accept)  idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovf <= 1'b0;
    else if (drop) ovf <= 1'b1;
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  words[i] <= '0;
      else if (accept && (idx == IDX_W'(i)))       words[i] <= wdata;
    end
  end
endmodule

// File: rtl/nfc_stat_reg.sv
module nfc_stat_reg
  import nfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  nfc_evt_t          evt,
  input  logic              req_set,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [MASK_W-1:0] mask,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  localparam int UNMASKED = STAT_W - MASK_W;

  logic [STAT_W-1:0] set_v;
  logic [STAT_W-1:0] enable_v;
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    set_v = '0;
    set_v[S_CMDREQ] = req_set;
    set_v[S_RDREQ]  = evt.rd_req;
    set_v[S_WRREQ]  = evt.wr_req;
    set_v[S_SBERR]  = evt.sb_err;
    set_v[S_DBERR]  = evt.db_err;
    if (cs) begin
      set_v[S_CDN1] = evt.cmd_done;
      set_v[S_PGD1] = evt.page_done;
      set_v[S_BBD1] = evt.bad_blk;
      set_v[S_RDY1] = evt.ready;
    end else begin
      set_v[S_CDN0] = evt.cmd_done;
      set_v[S_PGD0] = evt.page_done;
      set_v[S_BBD0] = evt.bad_blk;
      set_v[S_RDY0] = evt.ready;
    end
  end

  assign enable_v = {{UNMASKED{1'b1}}, ~mask};
  assign stat_d   = (stat & ~(clr_wr ? clr_bits : '0)) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_d;
      irq  <= |(stat & enable_v);
    end
  end
endmodule

// File: rtl/nfc_host_if.sv
module nfc_host_if
  import nfc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      evt_cmd_done,
  input  logic                      evt_page_done,
  input  logic                      evt_bad_blk,
  input  logic                      evt_ready,
  input  logic                      evt_rd_req,
  input  logic                      evt_wr_req,
  input  logic                      evt_sb_err,
  input  logic                      evt_db_err,
  output logic                      run,
  output logic                      irq,
  output logic                      cmd_loaded,
  output logic                      cmd_ovf,
  output logic                      cmd_cs,
  output logic [N_WORDS*DATA_W-1:0] cmd_words
);
  logic                           wr_ctrl, wr_stat, wr_cmd;
  logic [MASK_W-1:0]              mask;
  logic                           run_rise, run_drop;
  logic [STAT_W-1:0]              stat_q;
  logic [N_WORDS-1:0][DATA_W-1:0] words;
  nfc_evt_t                       evt;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));

  assign evt = '{cmd_done: evt_cmd_done, page_done: evt_page_done,
                 bad_blk: evt_bad_blk, ready: evt_ready,
                 rd_req: evt_rd_req, wr_req: evt_wr_req,
                 sb_err: evt_sb_err, db_err: evt_db_err};

  nfc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_run   (bus_wdata[RUN_POS]),
    .wr_mask  (bus_wdata[MASK_W-1:0]),
    .auto_clr (evt_cmd_done),
    .run      (run),
    .mask     (mask),
    .run_rise (run_rise),
    .run_drop (run_drop)
  );

  nfc_cmd_buf #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (run_rise || run_drop),
    .wr_cmd  (wr_cmd),
    .run     (run),
    .wdata   (bus_wdata),
    .words   (words),
    .loaded  (cmd_loaded),
    .ovf     (cmd_ovf)
  );

  assign cmd_cs = words[0][CS_POS];

  nfc_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cmd_cs),
    .evt      (evt),
    .req_set  (run_rise),
    .clr_wr   (wr_stat),
    .clr_bits (bus_wdata[STAT_W-1:0]),
    .mask     (mask),
    .stat     (stat_q),
    .irq      (irq)
  );

  for (genvar i = 0; i < N_WORDS; i++) begin : g_out
    assign cmd_words[i*DATA_W +: DATA_W] = words[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      bus_rdata[RUN_POS]      = run;
      bus_rdata[MASK_W-1:0]   = mask;
    end else if (bus_addr == ADDR_W'(A_STAT)) begin
      bus_rdata[STAT_W-1:0]   = stat_q;
    end
    for (int i = 0; i < N_WORDS; i++) begin
      if (bus_addr == ADDR_W'(A_CMD + 4*i)) bus_rdata = words[i];
    end
  end
endmodule

// File: rtl/nfc_host_if_chk.sv
module nfc_host_if_chk
  import nfc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [STAT_W-1:0]         wdata_lo,
  input logic                      evt_any,
  input logic                      evt_cmd_done,
  input logic                      run,
  input logic                      irq,
  input logic                      cmd_loaded,
  input logic                      cmd_ovf,
  input logic [N_WORDS*DATA_W-1:0] cmd_words,
  input logic [STAT_W-1:0]         stat
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));

  // R2
  cmd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> stat[S_CMDREQ]);

  // R3
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cmd_words));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_loaded && !ctrl_wr) |=> $stable(cmd_words));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ovf |=> cmd_ovf);

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_STAT) && (&wdata_lo) && !evt_any)
      |=> (stat == '0));

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |=> !irq);

  // R10
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && evt_cmd_done && !ctrl_wr) |=> !run);
endmodule

bind nfc_host_if nfc_host_if_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .wdata_lo     (bus_wdata[12:0]),
  .evt_any      (evt_cmd_done | evt_page_done | evt_bad_blk | evt_ready |
                 evt_rd_req | evt_wr_req | evt_sb_err | evt_db_err),
  .evt_cmd_done (evt_cmd_done),
  .run          (run),
  .irq          (irq),
  .cmd_loaded   (cmd_loaded),
  .cmd_ovf      (cmd_ovf),
  .cmd_words    (cmd_words),
  .stat         (stat_q)
);

// File: tb/nfc_host_if_tb.sv
module nfc_host_if_tb;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NW = 3;
  localparam logic [7:0] CTRL = 8'h00, STAT = 8'h04, CMD0 = 8'h08, CMD1 = 8'h0C, CMD2 = 8'h10;
  localparam logic [31:0] RUNB = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic e_cd = 0, e_pd = 0, e_bb = 0, e_rdy = 0, e_rq = 0, e_wq = 0, e_sb = 0, e_db = 0;
  logic run, irq, cmd_loaded, cmd_ovf, cmd_cs;
  logic [NW*DW-1:0] cmd_words;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  nfc_host_if #(.DATA_W(DW), .ADDR_W(AW), .N_WORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_cmd_done(e_cd), .evt_page_done(e_pd), .evt_bad_blk(e_bb), .evt_ready(e_rdy),
    .evt_rd_req(e_rq), .evt_wr_req(e_wq), .evt_sb_err(e_sb), .evt_db_err(e_db),
    .run(run), .irq(irq), .cmd_loaded(cmd_loaded), .cmd_ovf(cmd_ovf),
    .cmd_cs(cmd_cs), .cmd_words(cmd_words));

  // monitor: pops expected read data, compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value, then presents the address
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic set_evt(input int k, input logic v);
    case (k)
      0: e_cd = v;  1: e_pd = v;  2: e_bb = v;  3: e_rdy = v;
      4: e_rq = v;  5: e_wq = v;  6: e_sb = v;  default: e_db = v;
    endcase
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1; set_evt(k, 1'b1);
    @(posedge clk); #1; set_evt(k, 1'b0);
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 run", {31'b0, run}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 loaded", {31'b0, cmd_loaded}, 0);
    chk("R1 ovf", {31'b0, cmd_ovf}, 0);
    rd(CTRL, 0, "R1 ctrl");
    rd(STAT, 0, "R1 stat");
    // R3 command write while idle
    wr(CMD0, 32'hAAAA_5555);
    rd(CMD0, 0, "R3 idle write ignored");
    chk("R3 loaded", {31'b0, cmd_loaded}, 0);
    // R2 arm with all masks set
    wr(CTRL, RUNB | 32'hFFF);
    chk("R2 run", {31'b0, run}, 1);
    rd(CTRL, 32'h1000_0FFF, "R2 ctrl readback");
    rd(STAT, 32'h001, "R2 command request");
    chk("R9 masked irq", {31'b0, irq}, 0);
    // R4 load order, chip 0
    wr(CMD0, 32'h0000_00A0);
    wr(CMD0, 32'h1122_3344);
    chk("R4 not yet loaded", {31'b0, cmd_loaded}, 0);
    wr(CMD0, 32'h5566_7788);
    chk("R4 loaded", {31'b0, cmd_loaded}, 1);
    rd(CMD0, 32'h0000_00A0, "R4 word0");
    rd(CMD1, 32'h1122_3344, "R4 word1");
    rd(CMD2, 32'h5566_7788, "R4 word2");
    chk("R7 cs0", {31'b0, cmd_cs}, 0);
    // R5 overflow
    wr(CMD0, 32'hDEAD_BEEF);
    chk("R5 ovf", {31'b0, cmd_ovf}, 1);
    rd(CMD0, 32'h0000_00A0, "R5 word0 kept");
    rd(CMD2, 32'h5566_7788, "R5 word2 kept");
    // R8 write-one-to-clear
    wr(STAT, 32'h1FFE);
    rd(STAT, 32'h001, "R8 zero leaves bit0");
    wr(STAT, 32'h001);
    rd(STAT, 32'h000, "R8 one clears bit0");
    // R7 chip 0 routing
    pulse(1); rd(STAT, 32'h400, "R7 cs0 page done");
    pulse(2); rd(STAT, 32'h440, "R7 cs0 bad block");
    pulse(3); rd(STAT, 32'hC40, "R7 cs0 ready");
    wr(STAT, 32'h1FFF);
    // R6 data and ECC events
    pulse(4); rd(STAT, 32'h002, "R6 read request");
    pulse(5); rd(STAT, 32'h006, "R6 write request");
    pulse(6); rd(STAT, 32'h00E, "R6 single-bit error");
    pulse(7); rd(STAT, 32'h01E, "R6 double-bit error");
    wr(STAT, 32'h1FFF);
    // R10 auto stop, R7 cs0 command done
    pulse(0);
    chk("R10 auto stop", {31'b0, run}, 0);
    chk("R10 loaded drops", {31'b0, cmd_loaded}, 0);
    rd(STAT, 32'h100, "R7 cs0 command done");
    // chip 1
    wr(CTRL, RUNB | 32'hFFF);
    wr(CMD0, 32'h0100_0000);
    wr(CMD0, 32'h0000_0001);
    wr(CMD0, 32'h0000_0002);
    chk("R7 cs1", {31'b0, cmd_cs}, 1);
    wr(STAT, 32'h1FFF);
    pulse(1); rd(STAT, 32'h200, "R7 cs1 page done");
    pulse(2); rd(STAT, 32'h220, "R7 cs1 bad block");
    pulse(3);
    chk("R9 irq one cycle late", {31'b0, irq}, 0);
    @(posedge clk); #1;
    chk("R9 unmaskable bit12", {31'b0, irq}, 1);
    rd(STAT, 32'h1220, "R7 cs1 ready");
    wr(STAT, 32'h1FFF);
    @(posedge clk); #1;
    chk("R9 irq falls", {31'b0, irq}, 0);
    pulse(0);
    rd(STAT, 32'h080, "R7 cs1 command done");
    chk("R10 auto stop cs1", {31'b0, run}, 0);
    // R8 set wins over clear, R9 unmasked source
    wr(STAT, 32'h1FFF);
    wr(CTRL, 32'h0);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 32'h002; e_rq = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; e_rq = 1'b0;
    rd(STAT, 32'h002, "R8 event beats clear");
    chk("R9 irq on unmasked", {31'b0, irq}, 1);
    wr(CTRL, 32'h002);
    @(posedge clk); #1;
    chk("R9 mask disables", {31'b0, irq}, 0);
    // R10 host stop and restart at word 0
    wr(CTRL, RUNB | 32'hFFF);
    wr(CMD0, 32'h0000_0077);
    wr(CTRL, 32'hFFF);
    chk("R10 host stop", {31'b0, run}, 0);
    wr(CTRL, RUNB | 32'hFFF);
    wr(CMD0, 32'h0000_00A1);
    wr(CMD0, 32'h0000_00A2);
    wr(CMD0, 32'h0000_00A3);
    rd(CMD0, 32'h0000_00A1, "R10 restart word0");
    rd(CMD2, 32'h0000_00A3, "R10 restart word2");
    chk("R10 loaded", {31'b0, cmd_loaded}, 1);
    chk("R5 ovf sticky", {31'b0, cmd_ovf}, 1);
    @(posedge clk); #1;
    summary();
  end
endmodule